// File: doc/BRIEF.md
# Conversion Offset and Overrange Stage

This stage sits after a 14-bit successive-approximation core and adjusts each finished conversion. A signed offset, written by the host as a 15-bit word, is added to the unsigned raw code when the core reports that a conversion is complete. The result appears one clock later, marked by a one-cycle valid pulse.

A clip control selects one of two output forms. With clipping on, the result is held to the 14-bit span and bit 14 flags a sum that fell outside it. With clipping off, the full sum leaves on 15 bits, so codes up to 17693 and small negative values can still be resolved.

An offset write is checked before it is stored. If the word is malformed or out of range, the held offset is kept and an error flag is raised.

Top module: `ofs_clip_stage`

## Requirements
- R1: After reset, res_valid is 0, res_data is 0, ofs_err is 0, and the held offset is 0. A conversion taken before any write therefore returns the raw code unchanged.
- R2: An offset word carries the offset in bits 11:0 as 12-bit two's complement. Bits 14:12 must be zero. A write with any of bits 14:12 set is rejected.
- R3: A write with bits 14:12 zero is accepted when its value is between -1310 and +1310 inclusive. Examples are 12'hE00 = -512 and 12'h51E = +1310. Any other value, such as 1311 or -1311 (12'hAE1), is rejected.
- R4: ofs_err shows the outcome of the most recent write. It is set one cycle after a rejected write and cleared one cycle after an accepted write. It holds its value while no write occurs. A rejected write leaves the held offset unchanged.
- R5: The sum is the raw code plus the held offset, taken as signed. With an offset of zero, the raw code passes through unchanged.
- R6: With clip_en high, a sum above 16383 gives res_data = 0x7FFF, which is bit 14 set and bits 13:0 all ones. A sum below 0 gives res_data = 0x4000, which is bit 14 set and bits 13:0 zero. A sum in range gives bit 14 clear and the sum in bits 13:0.
- R7: With clip_en low, res_data is the sum taken modulo 2^15. Examples are 16383 + 1024 = 17407, and 0 + (-1310) = 31458, the 15-bit two's complement of the negative value.
- R8: res_valid pulses for exactly one cycle, one clock after each cycle in which raw_valid is high. res_data updates at that same edge and holds in all other cycles.
- R9: If an offset write and raw_valid occur in the same cycle, that conversion uses the previously held offset. The new offset applies from the next conversion on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_data | input | 14 | Unsigned raw conversion code |
| raw_valid | input | 1 | Raw code is complete this cycle |
| clip_en | input | 1 | 1 selects saturating output with overrange flag |
| ofs_wr | input | 1 | Offset write strobe |
| ofs_wdata | input | 15 | Offset word (bits 14:12 zero, bits 11:0 signed) |
| res_data | output | 15 | Adjusted result |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| ofs_err | output | 1 | Most recent offset write was rejected |

## Verification
The hardest condition to reach is a rejected write whose effect on the held offset can only be seen through a later conversion. Corrupting the held offset without disturbing the error flag needs a deliberate sequence. The stimulus therefore walks all 32768 offset words back to back, checking the flag after each one, and then confirms through a conversion that only the last accepted word is in force. The sum and clip paths are swept over eight offsets that include both range limits, in both clip modes. The raw codes are stepped, and the codes next to every saturation edge are added. A conversion in the same cycle as a write is applied on its own to pin down which offset is used.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
  typedef enum logic [1:0] {
    RNG_IN   = 2'd0,
    RNG_HIGH = 2'd1,
    RNG_LOW  = 2'd2
  } rng_e;
endpackage

// File: rtl/ocs_offset_reg.sv
module ocs_offset_reg #(
  parameter int OFS_W  = 12,
  parameter int WORD_W = 15,
  parameter int LIMIT  = 1310
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [WORD_W-1:0]       wr_word,
  output logic signed [OFS_W-1:0] ofs_q,
  output logic                    err_q
);
  localparam int HI_W = WORD_W - OFS_W;

  logic                    hi_ok, rng_ok, accept;
  logic signed [OFS_W-1:0] wr_val, ofs_d;
  logic                    err_d;

  always_comb begin
    wr_val = $signed(wr_word[OFS_W-1:0]);
    hi_ok  = (wr_word[WORD_W-1:OFS_W] == {HI_W{1'b0}});
    rng_ok = (int'(wr_val) >= -LIMIT) && (int'(wr_val) <= LIMIT);
    accept = wr_en && hi_ok && rng_ok;
    ofs_d  = accept ? wr_val : ofs_q;
    err_d  = wr_en ? !(hi_ok && rng_ok) : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
      err_q <= 1'b0;
    end else begin
      ofs_q <= ofs_d;
      err_q <= err_d;
    end
  end

  // R2: a word with upper bits set never reaches the register
  a_r2_upper_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_word[WORD_W-1:OFS_W] != '0) |=> (err_q && $stable(ofs_q)));

  // R3: the held offset stays inside the allowed window
  a_r3_held_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ofs_q) >= -LIMIT) && (int'(ofs_q) <= LIMIT));

  // R4: without a write, neither offset nor flag moves
  a_r4_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ofs_q) && $stable(err_q)));
endmodule

// File: rtl/ocs_sum_clip.sv
module ocs_sum_clip
  import ocs_pkg::*;
#(
  parameter int RAW_W = 14,
  parameter int OFS_W = 12
) (
  input  logic [RAW_W-1:0]        raw,
  input  logic signed [OFS_W-1:0] ofs,
  input  logic                    clip_en,
  output logic [RAW_W:0]          result
);
  localparam int SUM_W = RAW_W + 2;
  localparam logic signed [SUM_W-1:0] FULL = SUM_W'((1 << RAW_W) - 1);

  logic signed [SUM_W-1:0] raw_s, ofs_s, sum;
  rng_e                    rng;

  always_comb begin
    raw_s = $signed({2'b00, raw});
    ofs_s = $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});
    sum   = raw_s + ofs_s;
    if (sum[SUM_W-1])  rng = RNG_LOW;
    else if (sum > FULL) rng = RNG_HIGH;
    else               rng = RNG_IN;
  end

  always_comb begin
    if (clip_en) begin
      unique case (rng)
        RNG_HIGH: result = {1'b1, {RAW_W{1'b1}}};
        RNG_LOW:  result = {1'b1, {RAW_W{1'b0}}};
        default:  result = {1'b0, sum[RAW_W-1:0]};
      endcase
    end else begin
      result = sum[RAW_W:0];
    end
  end
endmodule

// File: rtl/ofs_clip_stage.sv
module ofs_clip_stage #(
  parameter int RAW_W  = 14,
  parameter int OFS_W  = 12,
  parameter int LIMIT  = 1310,
  localparam int WORD_W = RAW_W + 1,
  localparam int RES_W  = RAW_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAW_W-1:0]  raw_data,
  input  logic              raw_valid,
  input  logic              clip_en,
  input  logic              ofs_wr,
  input  logic [WORD_W-1:0] ofs_wdata,
  output logic [RES_W-1:0]  res_data,
  output logic              res_valid,
  output logic              ofs_err
);
  logic signed [OFS_W-1:0] ofs_held;
  logic [RES_W-1:0]        res_next, res_q;
  logic                    vld_q;

  ocs_offset_reg #(.OFS_W(OFS_W), .WORD_W(WORD_W), .LIMIT(LIMIT)) u_ofs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ofs_wr),
    .wr_word(ofs_wdata),
    .ofs_q  (ofs_held),
    .err_q  (ofs_err)
  );

  ocs_sum_clip #(.RAW_W(RAW_W), .OFS_W(OFS_W)) u_sum (
    .raw    (raw_data),
    .ofs    (ofs_held),
    .clip_en(clip_en),
    .result (res_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= raw_valid;
      if (raw_valid) res_q <= res_next;
    end
  end

  assign res_data  = res_q;
  assign res_valid = vld_q;

  // R8: each raw strobe yields exactly one output pulse
  a_r8_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
    raw_valid |=> res_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_valid |=> !res_valid);
  a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_valid |=> $stable(res_data));

  // R6: a flagged clipped result is pinned to a rail
  a_r6_clip_rails: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_valid && clip_en) |=>
      (!res_data[RAW_W] || res_data[RAW_W-1:0] == '0 || res_data[RAW_W-1:0] == '1));
endmodule

// File: tb/ofs_clip_stage_tb_top.sv
module ofs_clip_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] raw_data;
  logic        raw_valid;
  logic        clip_en;
  logic        ofs_wr;
  logic [14:0] ofs_wdata;
  logic [14:0] res_data;
  logic        res_valid;
  logic        ofs_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int model_ofs = 0;

  always #2 clk = ~clk;

  ofs_clip_stage dut_i (
    .clk(clk), .rst_n(rst_n), .raw_data(raw_data), .raw_valid(raw_valid),
    .clip_en(clip_en), .ofs_wr(ofs_wr), .ofs_wdata(ofs_wdata),
    .res_data(res_data), .res_valid(res_valid), .ofs_err(ofs_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int expect_res(input int raw, input int ofs, input bit clip);
    int s = raw + ofs;
    if (clip) begin
      if (s > 16383) return 32767;
      if (s < 0)     return 16384;
      return s;
    end
    return s & 32'h7FFF;
  endfunction

  function automatic bit word_ok(input int w);
    int v = w & 12'hFFF;
    if (v >= 2048) v = v - 4096;
    return ((w >> 12) == 0) && (v >= -1310) && (v <= 1310);
  endfunction

  function automatic int word_val(input int w);
    int v = w & 12'hFFF;
    if (v >= 2048) v = v - 4096;
    return v;
  endfunction

  task automatic wr(input int w, input string req);
    @(negedge clk);
    ofs_wr = 1'b1; ofs_wdata = w[14:0];
    @(posedge clk); #1;
    chk(ofs_err == !word_ok(w), req, int'(ofs_err), int'(!word_ok(w)));
    if (word_ok(w)) model_ofs = word_val(w);
  endtask

  task automatic conv(input int raw, input bit clip, input string req);
    int e = expect_res(raw, model_ofs, clip);
    @(negedge clk);
    ofs_wr = 1'b0; raw_valid = 1'b1; raw_data = raw[13:0]; clip_en = clip;
    @(posedge clk); #1;
    chk(res_valid && int'(res_data) == e, req, int'(res_data), e);
    @(negedge clk);
    raw_valid = 1'b0; raw_data = ~raw[13:0];
    @(posedge clk); #1;
    chk(!res_valid && int'(res_data) == e, "R8 hold", int'(res_data), e);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int offs[8] = '{0, 1, -1, 256, -512, 1024, 1310, -1310};
    rst_n = 1'b0; raw_data = '0; raw_valid = 1'b0; clip_en = 1'b0;
    ofs_wr = 1'b0; ofs_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(res_valid == 1'b0, "R1 valid", int'(res_valid), 0);
    chk(res_data == '0, "R1 data", int'(res_data), 0);
    chk(ofs_err == 1'b0, "R1 err", int'(ofs_err), 0);
    conv(1234, 1'b0, "R1 zero offset");
    conv(16383, 1'b1, "R5 passthrough");

    // R2 R3 R4: every offset word, back to back
    for (int w = 0; w < 32768; w++) wr(w, "R2/R3 write check");
    @(negedge clk); ofs_wr = 1'b0;
    conv(100, 1'b0, "R4 rejected words kept offset");  // last accepted word is -1

    // R4: flag holds between writes, accepted write clears it
    wr(15'h0AE1, "R3 reject -1311");
    @(posedge clk); #1;
    chk(ofs_err == 1'b1, "R4 flag holds", int'(ofs_err), 1);
    conv(50, 1'b1, "R4 offset unchanged after reject");
    wr(15'h051F, "R3 reject 1311");
    wr(15'h051E, "R3 accept 1310");
    chk(model_ofs == 1310, "R3 model", model_ofs, 1310);
    conv(0, 1'b0, "R3 offset 1310 applied");

    // R5 R6 R7 sweep
    foreach (offs[i]) begin
      wr(offs[i] & 12'hFFF, "R3 sweep write");
      for (int c = 0; c < 2; c++) begin
        int edges[7] = '{0, 1, 16382, 16383, -offs[i], -offs[i] - 1, 16384 - offs[i]};
        for (int r = 0; r < 16384; r += 97)
          conv(r, c[0], c[0] ? "R6 clipped sweep" : "R7 unclipped sweep");
        foreach (edges[k])
          if (edges[k] >= 0 && edges[k] <= 16383)
            conv(edges[k], c[0], c[0] ? "R6 rail edge" : "R7 wrap edge");
      end
    end

    // R9: write and conversion in the same cycle use the old offset
    wr(15'h0100, "R9 set 256");
    @(negedge clk);
    ofs_wr = 1'b1; ofs_wdata = 15'h0E00;
    raw_valid = 1'b1; raw_data = 14'd1000; clip_en = 1'b0;
    @(posedge clk); #1;
    chk(res_valid && res_data == 15'd1256, "R9 old offset used", int'(res_data), 1256);
    @(negedge clk); ofs_wr = 1'b0; raw_valid = 1'b0;
    model_ofs = -512;
    conv(1000, 1'b0, "R9 new offset next");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule